// File: doc/BRIEF.md
# Four-Phase Handshake Bus Master

This block is a clocked initiator for a shared, non-multiplexed asynchronous bus. The bus has separate address lines, data lines with a direction flag, a request line driven by the block and an acknowledge line driven by the addressed target. The block carries out one read or one write per command taken from a local command port. Each transfer uses a full four-phase request/acknowledge handshake. The block drives address and direction first, and drives write data as well on a write. It then waits a programmable number of cycles so that targets can decode the address, and only then raises the request.

The target raises acknowledge once it has taken write data, or once read data is valid on the bus. The block then drops the request and latches read data at that same edge. It waits for acknowledge to fall before it reports completion and takes another command. Acknowledge comes from outside the clock domain and is resynchronised through two flip-flops before the sequencer uses it. If acknowledge never arrives, a watchdog ends the request after a fixed number of cycles and reports a timeout.

The command port is valid/ready. A command (direction, address, write data) is taken on a cycle where both `cmd_valid_i` and `cmd_ready_o` are high. While `cmd_ready_o` is low, the source must hold the command stable. The response side has no back-pressure: `rsp_valid_o` is a one-cycle pulse and must be consumed when it occurs.

Top module: `hsk_bus_master`

## Requirements
- R1: During and right after reset, `bus_req_o`, `bus_addr_oe_o`, `bus_data_oe_o` and `rsp_valid_o` are low and `cmd_ready_o` is high.
- R2: From the cycle after a command is taken, address and direction are driven (`bus_addr_oe_o` high, `bus_write_o` = 1 for write, 0 for read). On a write `bus_data_oe_o` is high with the write data on `bus_wdata_o`. On a read `bus_data_oe_o` stays low for the whole transfer.
- R3: After the address is first driven, `bus_req_o` stays low for exactly `SETTLE` cycles (`SETTLE` >= 1) and then rises.
- R4: `bus_req_o` stays high until acknowledge is seen through the two-stage synchroniser. It falls on the third rising clock edge after `bus_ack_i` rises.
- R5: On a read, `rsp_rdata_o` takes the value of `bus_rdata_i` at the edge where `bus_req_o` falls. It holds that value until the next completed read.
- R6: A completed transfer gives one single-cycle `rsp_valid_o` pulse with `rsp_timeout_o` = 0, after synchronised acknowledge has fallen. No command is taken while synchronised acknowledge is high.
- R7: Address and direction stay stable while `bus_addr_oe_o` is high. They are released only after acknowledge has fallen.
- R8: If no acknowledge is seen within `ACK_TIMEOUT` cycles of the request, `bus_req_o` falls after exactly `ACK_TIMEOUT` high cycles. The block then pulses `rsp_valid_o` with `rsp_timeout_o` = 1 and returns to idle.
- R9: `cmd_ready_o` is low from the moment a command is taken until the transfer completes or times out. A command held pending during that time is taken afterwards, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | AW | Command address |
| cmd_wdata_i | input | DW | Command write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_timeout_o | output | 1 | Completion was a watchdog timeout |
| rsp_rdata_o | output | DW | Data latched on the last read |
| bus_addr_o | output | AW | Bus address value |
| bus_addr_oe_o | output | 1 | Drive enable for address and direction |
| bus_write_o | output | 1 | Bus direction, 1 = write |
| bus_wdata_o | output | DW | Bus write data value |
| bus_data_oe_o | output | 1 | Drive enable for bus data (writes only) |
| bus_rdata_i | input | DW | Bus data as seen by the block |
| bus_req_o | output | 1 | Handshake request |
| bus_ack_i | input | 1 | Handshake acknowledge, asynchronous |

## Verification
Assertions check the rules that hold on every cycle:
- data drive enabled only on writes;
- request held until synchronised acknowledge or watchdog expiry, and dropped right after acknowledge;
- address and direction stable while driven;
- no command taken while acknowledge is seen high;
- single-cycle response pulses.

The bench scenarios are needed for the rest:
- the exact settle length;
- the three-edge acknowledge-to-release latency;
- that read data is latched when the request falls and not when acknowledge falls, since the target model corrupts the data lines as it lowers acknowledge;
- the exact watchdog length;
- the gating of a new command behind a late acknowledge that arrives after a timeout.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_REQ     = 2'd2,
    ST_RELEASE = 2'd3
  } hsk_state_e;
endpackage

// File: rtl/hsk_sync2.sv
module hsk_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsk_timer.sv
module hsk_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load_i)     cnt_q <= load_val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hsk_seq.sv
module hsk_seq
  import hsk_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int SETTLE      = 2,
  parameter int ACK_TIMEOUT = 16,
  parameter int CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic          ack_s_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          rsp_valid_o,
  output logic          rsp_timeout_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_addr_oe_o,
  output logic          bus_write_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_data_oe_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_req_o
);
  hsk_state_e    state_q, state_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q, req_q, drive_q, rsp_q, tmo_q;
  logic          accept, finish, expire, capture;

  assign cmd_ready_o = (state_q == ST_IDLE) && !ack_s_i;
  assign accept      = cmd_valid_i && cmd_ready_o;

  always_comb begin
    state_n    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    finish     = 1'b0;
    expire     = 1'b0;
    capture    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_n    = ST_SETTLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(SETTLE - 1);
      end
      ST_SETTLE: if (tmr_zero_i) begin
        state_n    = ST_REQ;
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(ACK_TIMEOUT - 1);
      end
      ST_REQ: if (ack_s_i) begin
        state_n = ST_RELEASE;
        capture = !wr_q;
      end else if (tmr_zero_i) begin
        state_n = ST_IDLE;
        expire  = 1'b1;
      end
      ST_RELEASE: if (!ack_s_i) begin
        state_n = ST_IDLE;
        finish  = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      drive_q <= 1'b0;
      rsp_q   <= 1'b0;
      tmo_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= (state_n == ST_REQ);
      drive_q <= (state_n != ST_IDLE);
      rsp_q   <= finish || expire;
      if (finish || expire) tmo_q <= expire;
      if (accept) begin
        addr_q  <= cmd_addr_i;
        wr_q    <= cmd_write_i;
        wdata_q <= cmd_wdata_i;
      end
      if (capture) rdata_q <= bus_rdata_i;
    end
  end

  assign bus_req_o     = req_q;
  assign bus_addr_oe_o = drive_q;
  assign bus_data_oe_o = drive_q && wr_q;
  assign bus_addr_o    = addr_q;
  assign bus_write_o   = wr_q;
  assign bus_wdata_o   = wdata_q;
  assign rsp_valid_o   = rsp_q;
  assign rsp_timeout_o = tmo_q;
  assign rsp_rdata_o   = rdata_q;

  a_r2_no_data_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe_o |-> (bus_write_o && bus_addr_oe_o));
  a_r3_req_after_address: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_o) |-> $past(bus_addr_oe_o));
  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !ack_s_i && !tmr_zero_i) |=> bus_req_o);
  a_r4_drop_req_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && ack_s_i) |=> !bus_req_o);
  a_r6_no_accept_while_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |-> !ack_s_i);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);
  a_r7_address_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_oe_o && $past(bus_addr_oe_o)) |-> ($stable(bus_addr_o) && $stable(bus_write_o)));
  a_r8_timeout_releases_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_timeout_o) |-> !bus_req_o);
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_oe_o |-> !cmd_ready_o);
endmodule

// File: rtl/hsk_bus_master.sv
module hsk_bus_master #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int SETTLE      = 2,
  parameter int ACK_TIMEOUT = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_timeout_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_addr_oe_o,
  output logic          bus_write_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_data_oe_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_req_o,
  input  logic          bus_ack_i
);
  localparam int TMAX = (SETTLE > ACK_TIMEOUT) ? SETTLE : ACK_TIMEOUT;
  localparam int CW   = $clog2(TMAX + 1);

  logic          ack_s, tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  hsk_sync2 #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(bus_ack_i), .q_o(ack_s)
  );

  hsk_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  hsk_seq #(
    .AW(AW), .DW(DW), .SETTLE(SETTLE), .ACK_TIMEOUT(ACK_TIMEOUT), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_write_i(cmd_write_i),
    .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i),
    .ack_s_i(ack_s), .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .rsp_valid_o(rsp_valid_o), .rsp_timeout_o(rsp_timeout_o), .rsp_rdata_o(rsp_rdata_o),
    .bus_addr_o(bus_addr_o), .bus_addr_oe_o(bus_addr_oe_o), .bus_write_o(bus_write_o),
    .bus_wdata_o(bus_wdata_o), .bus_data_oe_o(bus_data_oe_o), .bus_rdata_i(bus_rdata_i),
    .bus_req_o(bus_req_o)
  );
endmodule

// File: tb/hsk_bus_master_bench.sv
`timescale 1ns/1ps
module hsk_bus_master_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int SETTLE = 3;
  localparam int ACK_TIMEOUT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_timeout;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic bus_addr_oe, bus_write, bus_data_oe, bus_req;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = 16'hDEAD;
  logic bus_ack = 1'b0;

  always #5 clk = ~clk;

  hsk_bus_master #(.AW(AW), .DW(DW), .SETTLE(SETTLE), .ACK_TIMEOUT(ACK_TIMEOUT)) u_hsk_bus_master (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .rsp_valid_o(rsp_valid), .rsp_timeout_o(rsp_timeout), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .bus_addr_oe_o(bus_addr_oe), .bus_write_o(bus_write),
    .bus_wdata_o(bus_wdata), .bus_data_oe_o(bus_data_oe), .bus_rdata_i(bus_rdata),
    .bus_req_o(bus_req), .bus_ack_i(bus_ack)
  );

  // mode 0: normal target, 1: silent target, 2: acknowledge arrives just too late
  typedef struct {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            mode;
    int            adly;
    int            rdly;
  } item_t;

  item_t         exp_q[$];
  logic [DW-1:0] model_mem [256];
  logic [DW-1:0] tgt_mem   [256];
  int  vectors = 0, miscompares = 0;
  bit  finished = 1'b0;

  function automatic logic [DW-1:0] seed(int i);
    return DW'(i * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: pushes expected item, then presents the command until taken
  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int mode, input int adly, input int rdly);
    item_t it;
    it.wr = wr; it.addr = a; it.mode = mode; it.adly = adly; it.rdly = rdly;
    if (wr) begin
      it.data = d;
      if (mode == 0) model_mem[a[7:0]] = d;
    end else begin
      it.data = model_mem[a[7:0]];
    end
    exp_q.push_back(it);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    #1;
    while (!cmd_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
  endtask

  // target model on the bus
  initial begin
    item_t it;
    for (int i = 0; i < 256; i++) tgt_mem[i] = seed(i);
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (bus_req && exp_q.size() > 0) begin
        it = exp_q[0];
        if (it.mode == 0) begin
          repeat (it.adly) @(negedge clk);
          if (it.wr) tgt_mem[bus_addr[7:0]] = bus_wdata;
          else       bus_rdata = tgt_mem[bus_addr[7:0]];
          bus_ack = 1'b1;
          while (bus_req) @(negedge clk);
          repeat (it.rdly) @(negedge clk);
          bus_ack = 1'b0;
          bus_rdata = 16'hDEAD;
        end else if (it.mode == 1) begin
          while (bus_req) @(negedge clk);
        end else begin
          repeat (ACK_TIMEOUT - 2) @(negedge clk);
          bus_ack = 1'b1;
          repeat (5) @(negedge clk);
          bus_ack = 1'b0;
        end
      end
    end
  end

  // monitor and scoreboard
  initial begin
    bit prev_oe = 0, prev_req = 0, prev_rsp = 0, seen_req = 0;
    bit [2:0] ack_hist = '0;
    int settle_cnt = 0, req_cnt = 0, ackreq_cnt = 0;
    item_t it;
    wait (rst_n);
    forever begin
      @(negedge clk); #1;
      if (bus_addr_oe && !prev_oe) begin
        chk(ack_hist[2] == 1'b0, "R6 command taken while acknowledge high", ack_hist[2], 0);
        settle_cnt = 0; seen_req = 0;
      end
      if (bus_addr_oe && !bus_req && !seen_req) settle_cnt++;
      if (bus_req && !prev_req) begin
        seen_req = 1; req_cnt = 0; ackreq_cnt = 0;
        it = exp_q[0];
        chk(settle_cnt == SETTLE, "R3 settle cycles before request", settle_cnt, SETTLE);
        chk(bus_addr == it.addr && bus_write == it.wr, "R2 address/direction driven",
            {bus_write, bus_addr}, {it.wr, it.addr});
        chk(bus_data_oe == it.wr, "R2 data drive matches direction", bus_data_oe, it.wr);
        if (it.wr) chk(bus_wdata == it.data, "R2 write data on bus", bus_wdata, it.data);
        chk(cmd_ready == 1'b0, "R9 not ready while busy", cmd_ready, 0);
      end
      if (bus_req) req_cnt++;
      if (bus_req && bus_ack) ackreq_cnt++;
      if (!bus_req && prev_req) begin
        it = exp_q[0];
        chk(bus_addr == it.addr && bus_write == it.wr, "R7 address stable at request drop",
            {bus_write, bus_addr}, {it.wr, it.addr});
        if (it.mode == 0)
          chk(ackreq_cnt == 3, "R4 request drop latency after acknowledge", ackreq_cnt, 3);
        else
          chk(req_cnt == ACK_TIMEOUT, "R8 request length on timeout", req_cnt, ACK_TIMEOUT);
      end
      if (rsp_valid) begin
        chk(!prev_rsp, "R6 response is single pulse", prev_rsp, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected response", 1, 0);
        end else begin
          it = exp_q.pop_front();
          chk(rsp_timeout == (it.mode != 0), "R8 timeout flag", rsp_timeout, (it.mode != 0));
          chk(!bus_req, "R8 request low at response", bus_req, 0);
          if (!it.wr && it.mode == 0)
            chk(rsp_rdata == it.data, "R5 read data latched at request drop", rsp_rdata, it.data);
        end
      end
      ack_hist = {ack_hist[1:0], bus_ack};
      prev_oe = bus_addr_oe; prev_req = bus_req; prev_rsp = rsp_valid;
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model_mem[i] = seed(i);
    repeat (3) @(negedge clk);
    #1;
    chk(!bus_req && !bus_addr_oe && !bus_data_oe && !rsp_valid && cmd_ready,
        "R1 reset outputs", {bus_req, bus_addr_oe, bus_data_oe, rsp_valid, cmd_ready}, 5'b00001);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!bus_req && !bus_addr_oe && cmd_ready, "R1 idle after reset",
        {bus_req, bus_addr_oe, cmd_ready}, 3'b001);

    // writes with different target speeds (R2, R3, R4)
    issue(1'b1, 16'h0010, 16'hA5A5, 0, 0, 0);
    issue(1'b1, 16'h0022, 16'h1234, 0, 3, 2);
    issue(1'b1, 16'h00FF, 16'hFFFF, 0, 1, 5);
    // reads back and an untouched location (R5)
    issue(1'b0, 16'h0010, '0, 0, 0, 1);
    issue(1'b0, 16'h0022, '0, 0, 4, 3);
    issue(1'b0, 16'h00FF, '0, 0, 2, 0);
    issue(1'b0, 16'h0041, '0, 0, 0, 4);
    // back-to-back commands held while busy (R9)
    for (int k = 0; k < 4; k++) issue(1'b1, AW'(16'h0080 + k), DW'(16'hC000 + k * 7), 0, k, 3 - k);
    for (int k = 0; k < 4; k++) issue(1'b0, AW'(16'h0080 + k), '0, 0, 3 - k, k);
    // silent target (R8), then normal traffic
    issue(1'b0, 16'h0050, '0, 1, 0, 0);
    issue(1'b1, 16'h0051, 16'h5151, 1, 0, 0);
    issue(1'b0, 16'h0010, '0, 0, 1, 1);
    // late acknowledge after timeout gates the next command (R6)
    issue(1'b0, 16'h0060, '0, 2, 0, 0);
    issue(1'b1, 16'h0061, 16'h6161, 0, 0, 1);
    issue(1'b0, 16'h0061, '0, 0, 2, 2);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
    chk(!bus_req && !bus_addr_oe && cmd_ready, "R6 idle after last response",
        {bus_req, bus_addr_oe, cmd_ready}, 3'b001);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule